// File: doc/BRIEF.md
# Serial Register Access Port with Control-Mode Handover

This block lets an external host read and write an on-chip register file over a three-wire serial link. The link has an active-low select, a serial clock and one bidirectional data line. The data line is split at the block edge into an input, an output and an output enable, and the pad is outside the block. All three pins are sampled in the system clock domain through synchronizers. Edges of the select and of the serial clock are detected there, so every serial event takes effect a fixed few system cycles after it occurs at the pin.

A transaction opens when select falls. A 16-bit instruction follows, most significant bit first. It carries a direction bit, a two-bit byte-count code and a 13-bit start address. Whole data bytes follow. The address steps by one after each byte. A write commits each byte as its last bit arrives. A read presents each bit after a serial clock falling edge, so the host can sample it on the next rising edge.

The block also owns the move from pin-controlled configuration to serial-controlled configuration. After reset it reports pin-control mode. The first select fall switches it permanently to serial-control mode. At that moment the levels on the data pin and the clock pin are stored as the initial output-standard and sample-format settings in the mode register. Register writes can change those settings later.

Top module: `spi_cfg_port`

## Requirements
- R1: After reset, `serial_mode`, `out_std`, `data_fmt`, `sdio_oe` and every register in `reg_image` are 0. Toggling the serial clock while select is high changes none of them.
- R2: On the first select fall, `serial_mode` becomes 1. The mode register (at `MODE_ADDR`) is loaded with bit 0 = the data pin level and bits [2:1] = {0, clock pin level}. Bit 0 = 1 means LVDS DDR output and 0 means CMOS. Format code 01 means two's complement and 00 means offset binary.
- R3: `serial_mode` never returns to 0. Later select falls do not reload the mode register, whatever the pin levels are.
- R4: The instruction is 16 bits, most significant bit first: bit 15 selects a read when 1 and a write when 0, bits 14:13 are the byte-count code, and bits 12:0 are the start address. A one-byte write stores its byte, MSB first, at that address.
- R5: Count codes 00, 01 and 10 allow 1, 2 and 3 data bytes. Further write bytes change no register. For further read bytes the data line is not driven.
- R6: Count code 11 streams bytes until select rises. The address increments by one after each byte, modulo 8192.
- R7: During the data phase of a read that is within its count, `sdio_oe` is 1 and `sdio_out` presents the addressed register MSB first, each bit updated after a serial clock fall. `sdio_oe` is 0 throughout writes and during the instruction.
- R8: A byte that is only partly shifted when select rises writes nothing.
- R9: `sdio_oe` is 0 within a few system cycles after select rises.
- R10: Mode register bit 0 drives `out_std` and bits [2:1] drive `data_fmt`. A register write can set any code, including 10 (Gray code), which only a write can select.
- R11: Addresses at or above `REG_COUNT` are decoded on all 13 bits. Writes to them change nothing, with no aliasing onto low registers, and reads from them return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_cs_n | input | 1 | Active-low transaction select |
| spi_sclk | input | 1 | Serial clock from the host |
| sdio_in | input | 1 | Data line level seen at the pad |
| sdio_out | output | 1 | Read data toward the pad |
| sdio_oe | output | 1 | Pad drive enable for the data line |
| serial_mode | output | 1 | 1 once serial-control mode is entered |
| out_std | output | 1 | Output standard selection (1 = LVDS DDR) |
| data_fmt | output | 2 | Sample format code |
| reg_image | output | REG_COUNT*8 | Flat register file contents, register i at bits [8i+7:8i] |

## Verification
The bench builds the block with `REG_COUNT` = 8 and `MODE_ADDR` = 2. With only eight registers, one streaming transfer runs off the end of the register file, and addresses such as 0x1001 test the full 13-bit decode against a register that exists. A read starting at 0x1FFF wraps to address 0 within two bytes. Placing the mode register in the middle of the file lets a partial byte sit right on it, so a discarded partial byte would show as a change in `out_std` or `data_fmt`.

// File: rtl/spi_cfg_pkg.sv
// Package: shared widths, phase and count-code types, and mode register layout
// for the serial register access port. Assumes the 16-bit instruction layout
// {direction, count code, 13-bit address}.
package spi_cfg_pkg;
    localparam int ADDR_W  = 13;
    localparam int INSTR_W = 16;
    localparam int BYTE_W  = 8;

    // Mode register bit positions
    localparam int STD_BIT = 0;
    localparam int FMT_LO  = 1;
    localparam int FMT_HI  = 2;

    // Sample format codes
    localparam logic [1:0] FMT_OFFSET = 2'b00;
    localparam logic [1:0] FMT_TWOS   = 2'b01;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'b00,
        PH_INSTR = 2'b01,
        PH_DATA  = 2'b10
    } phase_t;

    typedef enum logic [1:0] {
        CNT_ONE    = 2'b00,
        CNT_TWO    = 2'b01,
        CNT_THREE  = 2'b10,
        CNT_STREAM = 2'b11
    } count_code_t;

    typedef struct packed {
        logic              rd;
        count_code_t       code;
        logic [ADDR_W-1:0] addr;
    } instr_t;
endpackage

// File: rtl/spi_pin_sync.sv
// Module: multi-stage synchronizer for a group of asynchronous pins.
// Assumes each pin is held long enough (several clk cycles) to be seen.
module spi_pin_sync #(
    parameter int               WIDTH   = 3,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pins,
    output logic [WIDTH-1:0] levels
);
    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            // first stage samples the raw pins
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[s] <= RST_VAL;
                else        stage_q[s] <= pins;
            end
        end else begin : g_next
            // later stages pass the value down the chain
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[s] <= RST_VAL;
                else        stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign levels = stage_q[STAGES-1];
endmodule

// File: rtl/spi_frame_engine.sv
// Module: transaction sequencer. It shifts in the 16-bit instruction, then
// handles whole data bytes: it issues a write strobe on each completed byte
// and presents read bits after serial clock falls. It enforces the byte-count
// code and steps the address. Assumes the event inputs are single-cycle pulses
// from synchronized pins and that a rise and a fall never coincide.
module spi_frame_engine
    import spi_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_active,
    input  logic              cs_fall,
    input  logic              sck_rise,
    input  logic              sck_fall,
    input  logic              sdi,
    input  logic [BYTE_W-1:0] rd_byte,
    output logic              wr_en,
    output logic [ADDR_W-1:0] acc_addr,
    output logic [BYTE_W-1:0] wr_data,
    output logic              sdo,
    output logic              sdo_en
);
    localparam int CNT_W = $clog2(INSTR_W);
    localparam int SEL_W = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] INSTR_LAST = CNT_W'(INSTR_W - 1);
    localparam logic [CNT_W-1:0] BYTE_LAST  = CNT_W'(BYTE_W - 1);

    phase_t            phase_q;
    logic [CNT_W-1:0]  bit_cnt_q;
    logic [INSTR_W-2:0] instr_sr_q;
    logic [BYTE_W-2:0] wr_sr_q;
    instr_t            hdr_q;
    instr_t            new_hdr;
    logic [ADDR_W-1:0] addr_q;
    logic [1:0]        bytes_done_q;
    logic              sdo_q;
    logic              in_limit;
    logic              byte_end;
    logic [SEL_W-1:0]  bit_sel;

    // decode of the instruction word as its last bit arrives
    assign new_hdr  = instr_t'({instr_sr_q, sdi});
    // current byte is still within the encoded count
    assign in_limit = (hdr_q.code == CNT_STREAM) || (bytes_done_q <= 2'(hdr_q.code));
    // eighth bit of a data byte is being received now
    assign byte_end = cs_active && !cs_fall && sck_rise &&
                      (phase_q == PH_DATA) && (bit_cnt_q == BYTE_LAST);
    // read bit index, MSB first
    assign bit_sel  = SEL_W'(BYTE_LAST - bit_cnt_q);

    // sequencing of instruction and data phases
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q      <= PH_IDLE;
            bit_cnt_q    <= '0;
            instr_sr_q   <= '0;
            wr_sr_q      <= '0;
            hdr_q        <= '0;
            addr_q       <= '0;
            bytes_done_q <= '0;
            sdo_q        <= 1'b0;
        end else if (cs_fall) begin
            phase_q      <= PH_INSTR;
            bit_cnt_q    <= '0;
            bytes_done_q <= '0;
        end else if (!cs_active) begin
            phase_q <= PH_IDLE;
            sdo_q   <= 1'b0;
        end else if (sck_rise) begin
            case (phase_q)
                PH_INSTR: begin
                    instr_sr_q <= {instr_sr_q[INSTR_W-3:0], sdi};
                    if (bit_cnt_q == INSTR_LAST) begin
                        hdr_q     <= new_hdr;
                        addr_q    <= new_hdr.addr;
                        phase_q   <= PH_DATA;
                        bit_cnt_q <= '0;
                    end else begin
                        bit_cnt_q <= bit_cnt_q + 1'b1;
                    end
                end
                PH_DATA: begin
                    wr_sr_q <= {wr_sr_q[BYTE_W-3:0], sdi};
                    if (bit_cnt_q == BYTE_LAST) begin
                        bit_cnt_q <= '0;
                        addr_q    <= addr_q + 1'b1;
                        if (bytes_done_q != 2'd3) bytes_done_q <= bytes_done_q + 1'b1;
                    end else begin
                        bit_cnt_q <= bit_cnt_q + 1'b1;
                    end
                end
                default: ;
            endcase
        end else if (sck_fall && (phase_q == PH_DATA) && hdr_q.rd) begin
            sdo_q <= rd_byte[bit_sel];
        end
    end

    assign wr_en    = byte_end && !hdr_q.rd && in_limit;
    assign wr_data  = {wr_sr_q, sdi};
    assign acc_addr = addr_q;
    assign sdo      = sdo_q;
    assign sdo_en   = cs_active && (phase_q == PH_DATA) && hdr_q.rd && in_limit;

    // independent count of writes in the current frame, for checking
    logic [1:0] wr_in_frame_q;
    always_ff @(posedge clk) begin
        if (!rst_n)                         wr_in_frame_q <= '0;
        else if (cs_fall)                   wr_in_frame_q <= '0;
        else if (wr_en && wr_in_frame_q != 2'd3) wr_in_frame_q <= wr_in_frame_q + 1'b1;
    end

    // R5
    byte_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && hdr_q.code != CNT_STREAM) |-> (wr_in_frame_q <= 2'(hdr_q.code)));

    // R6
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_end |=> (addr_q == $past(addr_q) + 1'b1));

    // R4
    instr_to_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_active && !cs_fall && sck_rise && phase_q == PH_INSTR && bit_cnt_q == INSTR_LAST)
        |=> (phase_q == PH_DATA && bit_cnt_q == '0));
endmodule

// File: rtl/spi_reg_bank.sv
// Module: byte-wide register file with a mode register. It tracks the
// pin-to-serial control handover and seeds the mode register from the pin
// levels on the first select fall. Assumes MODE_ADDR < REG_COUNT and that
// a write strobe never coincides with the handover event.
module spi_reg_bank
    import spi_cfg_pkg::*;
#(
    parameter int REG_COUNT = 32,
    parameter int MODE_ADDR = 5
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        enter_req,
    input  logic                        sdi_lvl,
    input  logic                        sck_lvl,
    input  logic                        wr_en,
    input  logic [ADDR_W-1:0]           addr,
    input  logic [BYTE_W-1:0]           wr_data,
    output logic [BYTE_W-1:0]           rd_data,
    output logic                        serial_mode,
    output logic                        out_std,
    output logic [1:0]                  data_fmt,
    output logic [REG_COUNT*BYTE_W-1:0] reg_image
);
    logic [BYTE_W-1:0] regs_q [REG_COUNT];
    logic              serial_q;
    logic              enter;
    logic [BYTE_W-1:0] mode_seed;

    // only the first select fall counts as the handover
    assign enter     = enter_req && !serial_q;
    // seed value: format from the clock pin, standard from the data pin
    assign mode_seed = BYTE_W'({(sck_lvl ? FMT_TWOS : FMT_OFFSET), sdi_lvl});

    // sticky serial-control flag
    always_ff @(posedge clk) begin
        if (!rst_n)     serial_q <= 1'b0;
        else if (enter) serial_q <= 1'b1;
    end

    for (genvar i = 0; i < REG_COUNT; i++) begin : g_reg
        // one register: full-width address match for writes, seed on handover
        always_ff @(posedge clk) begin
            if (!rst_n)                             regs_q[i] <= '0;
            else if (wr_en && addr == ADDR_W'(i))   regs_q[i] <= wr_data;
            else if (i == MODE_ADDR && enter)       regs_q[i] <= mode_seed;
        end
        assign reg_image[i*BYTE_W +: BYTE_W] = regs_q[i];
    end

    // read multiplexer; unmapped addresses return zero
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < REG_COUNT; i++) begin
            if (addr == ADDR_W'(i)) rd_data = regs_q[i];
        end
    end

    assign serial_mode = serial_q;
    assign out_std     = regs_q[MODE_ADDR][STD_BIT];
    assign data_fmt    = regs_q[MODE_ADDR][FMT_HI:FMT_LO];

    // R3
    mode_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        serial_q |=> serial_q);

    // R2
    mode_seed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        enter |=> (out_std == $past(sdi_lvl) && data_fmt == {1'b0, $past(sck_lvl)}));
endmodule

// File: rtl/spi_cfg_port.sv
// Module: top of the serial register access port. It synchronizes the three
// pins, derives select and serial clock edges, and connects the frame engine
// to the register bank. Assumes the pins change no faster than every few clk
// cycles and that the pad combines sdio_out/sdio_oe with sdio_in externally.
module spi_cfg_port
    import spi_cfg_pkg::*;
#(
    parameter int REG_COUNT   = 32,
    parameter int MODE_ADDR   = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        spi_cs_n,
    input  logic                        spi_sclk,
    input  logic                        sdio_in,
    output logic                        sdio_out,
    output logic                        sdio_oe,
    output logic                        serial_mode,
    output logic                        out_std,
    output logic [1:0]                  data_fmt,
    output logic [REG_COUNT*BYTE_W-1:0] reg_image
);
    localparam int PIN_N = 3;   // [2] select, [1] serial clock, [0] data

    logic [PIN_N-1:0]  pin_lvl;
    logic [1:0]        prev_q;  // [1] select, [0] serial clock
    logic              cs_fall, cs_rise, sck_rise, sck_fall, cs_active;
    logic              wr_en;
    logic [ADDR_W-1:0] acc_addr;
    logic [BYTE_W-1:0] wr_data, rd_data;

    spi_pin_sync #(
        .WIDTH  (PIN_N),
        .STAGES (SYNC_STAGES),
        .RST_VAL(3'b100)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pins  ({spi_cs_n, spi_sclk, sdio_in}),
        .levels(pin_lvl)
    );

    // previous synchronized levels for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 2'b10;
        else        prev_q <= pin_lvl[2:1];
    end

    assign cs_active = !pin_lvl[2];
    assign cs_fall   = prev_q[1] && !pin_lvl[2];
    assign cs_rise   = !prev_q[1] && pin_lvl[2];
    assign sck_rise  = !prev_q[0] && pin_lvl[1];
    assign sck_fall  = prev_q[0] && !pin_lvl[1];

    spi_frame_engine u_engine (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_active(cs_active),
        .cs_fall  (cs_fall),
        .sck_rise (sck_rise),
        .sck_fall (sck_fall),
        .sdi      (pin_lvl[0]),
        .rd_byte  (rd_data),
        .wr_en    (wr_en),
        .acc_addr (acc_addr),
        .wr_data  (wr_data),
        .sdo      (sdio_out),
        .sdo_en   (sdio_oe)
    );

    spi_reg_bank #(
        .REG_COUNT(REG_COUNT),
        .MODE_ADDR(MODE_ADDR)
    ) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .enter_req  (cs_fall),
        .sdi_lvl    (pin_lvl[0]),
        .sck_lvl    (pin_lvl[1]),
        .wr_en      (wr_en),
        .addr       (acc_addr),
        .wr_data    (wr_data),
        .rd_data    (rd_data),
        .serial_mode(serial_mode),
        .out_std    (out_std),
        .data_fmt   (data_fmt),
        .reg_image  (reg_image)
    );

    // R9
    oe_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_rise |=> !sdio_oe);
endmodule

// File: tb/spi_cfg_port_tb.sv
module spi_cfg_port_tb;
    localparam int NREG = 8;
    localparam int MODE = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1;
    logic sclk = 1'b0;
    logic sdi = 1'b0;
    logic sdio_out, sdio_oe, serial_mode, out_std;
    logic [1:0] data_fmt;
    logic [NREG*8-1:0] reg_image;

    spi_cfg_port #(.REG_COUNT(NREG), .MODE_ADDR(MODE)) u_dut (
        .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sclk(sclk), .sdio_in(sdi),
        .sdio_out(sdio_out), .sdio_oe(sdio_oe), .serial_mode(serial_mode),
        .out_std(out_std), .data_fmt(data_fmt), .reg_image(reg_image)
    );

    always #2 clk = ~clk;   // 250 MHz

    int checks = 0;
    int fails = 0;
    bit settled = 1'b0;
    bit done = 1'b0;
    logic [7:0] mdl [NREG];
    bit mdl_serial = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [NREG*8-1:0] image();
        logic [NREG*8-1:0] v;
        for (int i = 0; i < NREG; i++) v[i*8 +: 8] = mdl[i];
        return v;
    endfunction

    // per-clock comparison against the reference model once it is settled
    always @(negedge clk) begin
        if (settled && !done) begin
            chk(reg_image == image(), "R4", "register image", reg_image, image());
            chk(serial_mode == mdl_serial, "R3", "serial mode flag", serial_mode, mdl_serial);
            chk({data_fmt, out_std} == mdl[MODE][2:0], "R10", "mode outputs",
                {data_fmt, out_std}, mdl[MODE][2:0]);
        end
    end

    task automatic hold();
        repeat (6) @(negedge clk);
    endtask

    task automatic sbit(input logic b, output logic rb, output logic roe);
        sclk = 1'b0;
        sdi  = b;
        hold();
        rb  = sdio_out;
        roe = sdio_oe;
        settled = 1'b0;
        sclk = 1'b1;
        hold();
    endtask

    task automatic cs_start(input logic dl, input logic cl);
        sdi  = dl;
        sclk = cl;
        hold();
        settled = 1'b0;
        cs_n = 1'b0;
        hold();
        if (!mdl_serial) begin
            mdl_serial = 1'b1;
            mdl[MODE]  = {5'b0, 1'b0, cl, dl};
        end
        settled = 1'b1;
    endtask

    task automatic cs_stop();
        hold();
        cs_n = 1'b1;
        hold();
        chk(sdio_oe == 1'b0, "R9", "line released after select high", sdio_oe, 0);
    endtask

    task automatic xfer(input logic rd, input logic [1:0] code, input logic [12:0] addr,
                        input logic [7:0] data[$], input int tail_bits);
        logic [15:0] ins;
        logic rb, roe;
        int limit;
        ins = {rd, code, addr};
        limit = (code == 2'd3) ? 1000 : int'(code) + 1;
        for (int i = 15; i >= 0; i--) begin
            sbit(ins[i], rb, roe);
            chk(roe == 1'b0, "R7", "no drive during instruction", roe, 0);
            settled = 1'b1;
        end
        foreach (data[k]) begin
            logic [12:0] a;
            logic [7:0] got;
            logic [7:0] exp;
            a   = addr + 13'(k);
            exp = (a < NREG) ? mdl[a] : 8'h00;
            got = 8'h00;
            for (int b = 7; b >= 0; b--) begin
                sbit(data[k][b], rb, roe);
                got[b] = rb;
                if (rd && k < limit)
                    chk(roe == 1'b1, "R7", "drive during counted read byte", roe, 1);
                else if (rd)
                    chk(roe == 1'b0, "R5", "no drive beyond byte count", roe, 0);
                else
                    chk(roe == 1'b0, "R7", "no drive during write", roe, 0);
                if (b == 0 && !rd && k < limit && a < NREG) mdl[a] = data[k];
                settled = 1'b1;
            end
            if (rd && k < limit) chk(got == exp, "R7", "read byte", got, exp);
        end
        for (int t = 0; t < tail_bits; t++) begin
            sbit(1'b1, rb, roe);
            settled = 1'b1;
        end
    endtask

    initial begin
        for (int i = 0; i < NREG; i++) mdl[i] = 8'h00;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        hold();
        settled = 1'b1;
        // R1 reset state
        chk(serial_mode == 1'b0, "R1", "serial_mode after reset", serial_mode, 0);
        chk(out_std == 1'b0, "R1", "out_std after reset", out_std, 0);
        chk(data_fmt == 2'b00, "R1", "data_fmt after reset", data_fmt, 0);
        chk(sdio_oe == 1'b0, "R1", "sdio_oe after reset", sdio_oe, 0);
        chk(reg_image == '0, "R1", "registers after reset", reg_image, 0);
        // R1 clock activity with select high does nothing
        for (int i = 0; i < 4; i++) begin
            sclk = 1'b1; sdi = 1'b1; hold();
            sclk = 1'b0; hold();
        end
        chk(serial_mode == 1'b0, "R1", "still pin mode", serial_mode, 0);

        // R2 first select fall seeds the mode register; R5 extra byte ignored
        cs_start(1'b1, 1'b1);
        chk(serial_mode == 1'b1, "R2", "serial mode entered", serial_mode, 1);
        chk(out_std == 1'b1, "R2", "out_std seeded from data pin", out_std, 1);
        chk(data_fmt == 2'b01, "R2", "format seeded from clock pin", data_fmt, 2'b01);
        xfer(1'b0, 2'd0, 13'd0, '{8'hA5, 8'h3C}, 0);
        cs_stop();
        chk(reg_image[7:0] == 8'hA5, "R4", "one-byte write", reg_image[7:0], 8'hA5);
        chk(reg_image[15:8] == 8'h00, "R5", "byte past count 00 dropped", reg_image[15:8], 0);

        // R3 second fall with other levels; R5 code 01
        cs_start(1'b0, 1'b0);
        chk(out_std == 1'b1, "R3", "no reseed on later fall", out_std, 1);
        chk(data_fmt == 2'b01, "R3", "format unchanged on later fall", data_fmt, 2'b01);
        xfer(1'b0, 2'd1, 13'd4, '{8'h11, 8'h22, 8'h33}, 0);
        cs_stop();
        chk(reg_image[6*8 +: 8] == 8'h00, "R5", "third byte past code 01 dropped",
            reg_image[6*8 +: 8], 0);

        // R5 code 10
        cs_start(1'b0, 1'b0);
        xfer(1'b0, 2'd2, 13'd5, '{8'h44, 8'h55, 8'h66, 8'h77}, 0);
        cs_stop();
        chk(reg_image[7*8 +: 8] == 8'h66, "R5", "third byte of code 10", reg_image[7*8 +: 8], 8'h66);

        // R6 streaming beyond the file; R11 out-of-range writes dropped
        cs_start(1'b0, 1'b0);
        xfer(1'b0, 2'd3, 13'd6, '{8'h81, 8'h82, 8'h83, 8'h84, 8'h85}, 0);
        cs_stop();
        chk(reg_image[7*8 +: 8] == 8'h82, "R6", "streamed second byte", reg_image[7*8 +: 8], 8'h82);
        chk(reg_image[7:0] == 8'hA5, "R11", "no wrap onto low registers", reg_image[7:0], 8'hA5);

        // R11 full decode, no aliasing
        cs_start(1'b0, 1'b0);
        xfer(1'b0, 2'd0, 13'h1001, '{8'hFF}, 0);
        cs_stop();
        chk(reg_image[15:8] == 8'h00, "R11", "high address does not alias", reg_image[15:8], 0);

        // R8 partial byte on the mode register discarded
        cs_start(1'b0, 1'b0);
        xfer(1'b0, 2'd3, 13'd1, '{8'h5A}, 5);
        cs_stop();
        chk(reg_image[15:8] == 8'h5A, "R8", "full byte kept", reg_image[15:8], 8'h5A);
        chk({data_fmt, out_std} == 3'b011, "R8", "partial byte discarded",
            {data_fmt, out_std}, 3'b011);

        // R10 mode register writes, Gray code only by write
        cs_start(1'b1, 1'b1);
        xfer(1'b0, 2'd0, 13'(MODE), '{8'h04}, 0);
        cs_stop();
        chk(out_std == 1'b0, "R10", "standard set to CMOS", out_std, 0);
        chk(data_fmt == 2'b10, "R10", "Gray format selected", data_fmt, 2'b10);
        cs_start(1'b0, 1'b0);
        xfer(1'b0, 2'd0, 13'(MODE), '{8'h03}, 0);
        cs_stop();
        chk({data_fmt, out_std} == 3'b011, "R10", "format and standard rewritten",
            {data_fmt, out_std}, 3'b011);

        // R7 streaming read, R5 read past count, R11 unmapped read and R6 wrap
        cs_start(1'b0, 1'b0);
        xfer(1'b1, 2'd3, 13'd4, '{8'h00, 8'h00, 8'h00, 8'h00}, 0);
        cs_stop();
        cs_start(1'b0, 1'b0);
        xfer(1'b1, 2'd0, 13'd5, '{8'h00, 8'h00}, 0);
        cs_stop();
        cs_start(1'b0, 1'b0);
        xfer(1'b1, 2'd1, 13'h1FFF, '{8'h00, 8'h00}, 0);
        cs_stop();
        // R9 select rises in the middle of a read byte
        cs_start(1'b0, 1'b0);
        xfer(1'b1, 2'd3, 13'd0, '{}, 3);
        cs_stop();

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule